// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Arbiter

This block is the request-handling core of an interrupt controller with eight request lines. Incoming requests are captured in a request register, either as levels or as rising edges. Each request can be gated off by its own mask bit. A resolver ranks the surviving requests under the current priority order and compares the best of them with the highest-ranked level already in service. The interrupt line to the processor is raised only when a pending request outranks everything in service.

The processor acknowledges with a single-cycle pulse. On that pulse the winning level moves from the request register into the in-service register, and the winner is reported on an acknowledge output. In-service bits are retired by end-of-interrupt commands, either by naming a level or by taking the highest one. In automatic mode the bit is never held at all.

The priority order is a rotation defined by one "lowest level" pointer. After reset the order is fixed, with level 0 ranked highest. The pointer moves when a command sets it, when a rotating end-of-interrupt retires a level, or, in automatic rotation, when a level is acknowledged. A two-state machine drives the interrupt line. Its states are `ST_IDLE` and `ST_RAISE`, and its transitions are *go_raise* (IDLE to RAISE when a request wins), *withdraw* (RAISE to IDLE when no request wins any more) and *acknowledge* (RAISE to IDLE on the acknowledge pulse).

Top module: `irq_arbiter`

## Requirements
- R1: After reset, the request, in-service and mask registers read zero, `int_out` is low, and the priority order runs from level 0 (highest) to level 7 (lowest).
- R2: With `edge_mode`=0, the request register follows `irq_in` one clock later. With `edge_mode`=1, a request bit is set by a rising edge of its input, and an input that stays high is not captured again after its bit is cleared.
- R3: A mask bit of 1 stops only its own level from interrupting or being acknowledged. A masked higher level does not block a lower unmasked one. `mask_we` loads `mask_wdata` into the mask register.
- R4: `int_out` rises only when an unmasked request ranks strictly above the highest-ranked in-service level. It rises two clocks after the input that causes it.
- R5: When `inta` is high in a cycle where `int_out` is high, `ack_valid` pulses in the next cycle with `ack_level` set to the winning level. In that same clock, the winner's request bit is cleared and, unless automatic end-of-interrupt is on, its in-service bit is set.
- R6: Command codes on `cmd_op` are 0 = non-specific end-of-interrupt and 1 = specific end-of-interrupt. Code 0 clears the highest-ranked set in-service bit. Code 1 clears the bit named by `cmd_level`.
- R7: With `auto_eoi`=1, an acknowledge leaves the in-service register unchanged.
- R8: With `auto_eoi`=1 and `auto_rotate`=1, an acknowledged level becomes the lowest priority. Code 2 does a non-specific end-of-interrupt and makes the cleared level the lowest. Code 3 does a specific end-of-interrupt and makes `cmd_level` the lowest.
- R9: Code 4 makes `cmd_level` the lowest priority without touching the in-service register. Priority then descends from `cmd_level`+1, wrapping around.
- R10: `inta` while `int_out` is low has no effect: no `ack_valid` pulse and no register change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | N | Request lines |
| edge_mode | input | 1 | 1 = rising-edge sensing, 0 = level sensing |
| auto_eoi | input | 1 | Automatic end-of-interrupt on acknowledge |
| auto_rotate | input | 1 | Rotate on acknowledge while automatic end-of-interrupt is on |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | N | New mask value |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (0..4) |
| cmd_level | input | LW | Level operand of the command |
| inta | input | 1 | Acknowledge pulse from the processor |
| int_out | output | 1 | Interrupt line to the processor |
| ack_valid | output | 1 | One-cycle pulse after a taken acknowledge |
| ack_level | output | LW | Level granted by the acknowledge |
| irr_o | output | N | Request register |
| isr_o | output | N | In-service register |
| imr_o | output | N | Mask register |

## Verification
The bench builds the block at its default of N = 8, so LW is 3 and the rotation pointer wraps from level 7 back to level 0. At this width the bench can drive every rotation case it uses: automatic rotation moving level 7 above level 0, a set-lowest command placing level 3 on top, and rotating end-of-interrupt commands moving the order twice in a row. Nested service is exercised with a higher level preempting a lower one, and with a lower level held off by the one in service.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    typedef enum logic [2:0] {
        OP_EOI_NS  = 3'd0,
        OP_EOI_SP  = 3'd1,
        OP_ROT_NS  = 3'd2,
        OP_ROT_SP  = 3'd3,
        OP_SET_LOW = 3'd4
    } arb_op_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_RAISE = 1'b1
    } arb_state_e;

endpackage

// File: rtl/irq_resolver.sv
// Finds the highest-ranked set bit of vec. Rank 0 is the level just above low.
module irq_resolver #(
    parameter int N  = 8,
    parameter int LW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    input  logic [LW-1:0] low,
    output logic          found,
    output logic [LW-1:0] idx,
    output logic [LW-1:0] rank
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        rank  = '0;
        for (int k = 0; k < N; k++) begin
            int p;
            p = (int'(low) + 1 + k) % N;
            if (!found && vec[p]) begin
                found = 1'b1;
                idx   = LW'(p);
                rank  = LW'(k);
            end
        end
    end
endmodule

// File: rtl/irq_req_reg.sv
// Request register with level or rising-edge capture.
module irq_req_reg #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         edge_mode,
    input  logic [N-1:0] irq_in,
    input  logic [N-1:0] clr,
    output logic [N-1:0] irr
);
    logic [N-1:0] prev_r;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_r <= '0;
            irr    <= '0;
        end else begin
            prev_r <= irq_in;
            if (edge_mode)
                irr <= (irr | (irq_in & ~prev_r)) & ~clr;
            else
                irr <= irq_in & ~clr;
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_arb_pkg::*;
#(
    parameter int N = 8,
    localparam int LW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  irq_in,
    input  logic          edge_mode,
    input  logic          auto_eoi,
    input  logic          auto_rotate,
    input  logic          mask_we,
    input  logic [N-1:0]  mask_wdata,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [LW-1:0] cmd_level,
    input  logic          inta,
    output logic          int_out,
    output logic          ack_valid,
    output logic [LW-1:0] ack_level,
    output logic [N-1:0]  irr_o,
    output logic [N-1:0]  isr_o,
    output logic [N-1:0]  imr_o
);
    localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

    arb_state_e    state_r, state_n;
    logic [N-1:0]  irr, isr_r, imr_r, live;
    logic [N-1:0]  ack_clr, isr_set, isr_clr;
    logic [LW-1:0] low_r, low_n;
    logic          req_found, isr_found, win, take;
    logic [LW-1:0] req_idx, req_rank, isr_idx, isr_rank;

    assign live = irr & ~imr_r;

    irq_req_reg #(.N(N)) u_req (
        .clk(clk), .rst_n(rst_n), .edge_mode(edge_mode),
        .irq_in(irq_in), .clr(ack_clr), .irr(irr)
    );

    irq_resolver #(.N(N), .LW(LW)) u_res_req (
        .vec(live), .low(low_r),
        .found(req_found), .idx(req_idx), .rank(req_rank)
    );

    irq_resolver #(.N(N), .LW(LW)) u_res_isr (
        .vec(isr_r), .low(low_r),
        .found(isr_found), .idx(isr_idx), .rank(isr_rank)
    );

    assign win  = req_found && (!isr_found || (req_rank < isr_rank));
    assign take = (state_r == ST_RAISE) && inta && win;

    // next-state logic: go_raise, withdraw, acknowledge
    always_comb begin
        state_n = state_r;
        unique case (state_r)
            ST_IDLE:  state_n = win ? ST_RAISE : ST_IDLE;
            ST_RAISE: state_n = (inta || !win) ? ST_IDLE : ST_RAISE;
            default:  state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_r <= ST_IDLE;
        else        state_r <= state_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_valid <= 1'b0;
            ack_level <= '0;
        end else begin
            ack_valid <= take;
            ack_level <= take ? req_idx : ack_level;
        end
    end

    assign ack_clr = take ? (ONE << req_idx) : '0;
    assign isr_set = (take && !auto_eoi) ? (ONE << req_idx) : '0;

    always_comb begin
        isr_clr = '0;
        low_n   = low_r;
        if (take && auto_eoi && auto_rotate)
            low_n = req_idx;
        if (cmd_valid) begin
            unique case (cmd_op)
                OP_EOI_NS: if (isr_found) isr_clr = ONE << isr_idx;
                OP_ROT_NS: if (isr_found) begin
                    isr_clr = ONE << isr_idx;
                    low_n   = isr_idx;
                end
                OP_EOI_SP: isr_clr = ONE << cmd_level;
                OP_ROT_SP: begin
                    isr_clr = ONE << cmd_level;
                    low_n   = cmd_level;
                end
                OP_SET_LOW: low_n = cmd_level;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_r <= '0;
            imr_r <= '0;
            low_r <= LW'(N - 1);
        end else begin
            isr_r <= (isr_r & ~isr_clr) | isr_set;
            low_r <= low_n;
            if (mask_we) imr_r <= mask_wdata;
        end
    end

    assign int_out = (state_r == ST_RAISE);
    assign irr_o   = irr;
    assign isr_o   = isr_r;
    assign imr_o   = imr_r;
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
    parameter int N = 8,
    localparam int LW = $clog2(N)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [N-1:0]  irq_in,
    input logic          edge_mode,
    input logic          auto_eoi,
    input logic          auto_rotate,
    input logic          mask_we,
    input logic [N-1:0]  mask_wdata,
    input logic          cmd_valid,
    input logic [2:0]    cmd_op,
    input logic [LW-1:0] cmd_level,
    input logic          inta,
    input logic          int_out,
    input logic          ack_valid,
    input logic [LW-1:0] ack_level,
    input logic [N-1:0]  irr_o,
    input logic [N-1:0]  isr_o,
    input logic [N-1:0]  imr_o
);
    assert_ack_needs_raise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> $past(int_out && inta));

    assert_int_has_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_out) |-> $past((irr_o & ~imr_o) != '0));

    assert_ack_unmasked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> ((($past(imr_o) >> ack_level) & {{(N-1){1'b0}}, 1'b1}) == '0));

    assert_ack_sets_isr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && !$past(auto_eoi) && !$past(cmd_valid)) |-> isr_o[ack_level]);

    assert_aeoi_keeps_isr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && int_out && auto_eoi && !cmd_valid) |=> $stable(isr_o));

    assert_spec_eoi_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd1 && !inta) |=> !isr_o[$past(cmd_level)]);
endmodule

bind irq_arbiter irq_arbiter_chk #(.N(N)) u_chk (.*);

// File: tb/irq_arbiter_test.sv
`timescale 1ns/1ps
module irq_arbiter_test;
    localparam int N  = 8;
    localparam int LW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_in = '0;
    logic          edge_mode = 1'b0, auto_eoi = 1'b0, auto_rotate = 1'b0;
    logic          mask_we = 1'b0;
    logic [N-1:0]  mask_wdata = '0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = '0;
    logic [LW-1:0] cmd_level = '0;
    logic          inta = 1'b0;
    logic          int_out, ack_valid;
    logic [LW-1:0] ack_level;
    logic [N-1:0]  irr_o, isr_o, imr_o;

    int total = 0, bad = 0;
    int exp_q[$];
    bit done = 0;

    always #2 clk = ~clk;

    irq_arbiter #(.N(N)) uut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops expected grants as the design reports them
    always @(negedge clk) begin
        if (rst_n && ack_valid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R10 unexpected ack", int'(ack_level), -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                chk(int'(ack_level) == e, "R5 ack_level", int'(ack_level), e);
            end
        end
    end

    task automatic wait_int(input string req);
        int n = 0;
        while (!int_out && n < 20) begin
            @(negedge clk);
            n++;
        end
        chk(int_out, req, int_out, 1);
    endtask

    task automatic do_ack(input int exp);
        exp_q.push_back(exp);
        inta = 1'b1;
        @(negedge clk);
        inta = 1'b0;
    endtask

    task automatic send_cmd(input logic [2:0] op, input int lvl);
        cmd_op = op;
        cmd_level = LW'(lvl);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk(int_out == 0, "R1 int_out", int_out, 0);
        chk(irr_o == 0 && isr_o == 0 && imr_o == 0, "R1 registers",
            int'({irr_o, isr_o, imr_o}), 0);

        // R10 stray acknowledge
        inta = 1'b1; idle(1); inta = 1'b0; idle(1);
        chk(isr_o == 0, "R10 isr untouched", isr_o, 0);

        // R2 level capture, R4 timing
        irq_in = 8'h28;
        idle(1);
        chk(irr_o == 8'h28, "R2 level capture", irr_o, 8'h28);
        chk(int_out == 0, "R4 not yet raised", int_out, 0);
        idle(1);
        chk(int_out == 1, "R4 raised after two clocks", int_out, 1);
        do_ack(3);
        chk(isr_o == 8'h08, "R5 isr set", isr_o, 8'h08);
        idle(4);
        chk(int_out == 0, "R4 lower level held off", int_out, 0);

        // R4 nesting: higher level preempts
        irq_in = 8'h2A;
        wait_int("R4 higher level raises");
        do_ack(1);
        chk(isr_o == 8'h0A, "R5 nested isr", isr_o, 8'h0A);
        irq_in = 8'h28;
        idle(2);
        send_cmd(3'd0, 0);
        chk(isr_o == 8'h08, "R6 non-specific eoi", isr_o, 8'h08);
        idle(3);
        chk(int_out == 0, "R4 equal level no raise", int_out, 0);
        irq_in = 8'h20;
        idle(1);
        send_cmd(3'd1, 3);
        chk(isr_o == 8'h00, "R6 specific eoi", isr_o, 0);
        wait_int("R4 level 5 raises");
        do_ack(5);
        irq_in = 8'h00;
        idle(1);
        send_cmd(3'd1, 5);
        chk(isr_o == 0, "R6 specific eoi level 5", isr_o, 0);

        // R3 masking
        mask_wdata = 8'h01; mask_we = 1'b1; idle(1); mask_we = 1'b0;
        chk(imr_o == 8'h01, "R3 mask write", imr_o, 8'h01);
        irq_in = 8'h05;
        wait_int("R3 unmasked lower level raises");
        do_ack(2);
        irq_in = 8'h00;
        idle(1);
        send_cmd(3'd1, 2);
        mask_wdata = 8'h00; mask_we = 1'b1; idle(1); mask_we = 1'b0;
        idle(2);

        // R2 edge mode
        edge_mode = 1'b1;
        idle(2);
        irq_in = 8'h10;
        wait_int("R2 edge raises");
        do_ack(4);
        chk(irr_o == 0, "R5 request cleared on ack", irr_o, 0);
        idle(3);
        chk(irr_o == 0, "R2 held input not recaptured", irr_o, 0);
        send_cmd(3'd1, 4);
        idle(3);
        chk(int_out == 0 && irr_o == 0, "R2 no retrigger after eoi",
            int'({int_out, irr_o}), 0);
        irq_in = 8'h00;
        idle(2);

        // R7 automatic eoi, R8 automatic rotation
        auto_eoi = 1'b1; auto_rotate = 1'b1;
        irq_in = 8'h40;
        wait_int("R7 raise level 6");
        do_ack(6);
        chk(isr_o == 0, "R7 isr not held", isr_o, 0);
        irq_in = 8'h00;
        idle(2);
        irq_in = 8'h81;
        wait_int("R8 raise after rotation");
        do_ack(7);
        wait_int("R8 level 0 next");
        do_ack(0);
        irq_in = 8'h00;
        auto_eoi = 1'b0; auto_rotate = 1'b0;
        idle(2);

        // R9 set lowest = 2, so 3 is highest
        send_cmd(3'd4, 2);
        chk(isr_o == 0, "R9 isr untouched", isr_o, 0);
        irq_in = 8'h0A;
        wait_int("R9 raise");
        do_ack(3);
        chk(isr_o == 8'h08, "R9 level 3 in service", isr_o, 8'h08);
        idle(3);
        chk(int_out == 0, "R9 level 1 ranked below 3", int_out, 0);
        // R8 rotating non-specific eoi: 3 lowest, level 1 now outranks nothing in service
        send_cmd(3'd2, 0);
        chk(isr_o == 0, "R8 rotate eoi clears", isr_o, 0);
        wait_int("R8 level 1 raises");
        do_ack(1);
        send_cmd(3'd3, 1);
        chk(isr_o == 0, "R8 rotate specific eoi", isr_o, 0);
        irq_in = 8'h00;
        idle(2);
        // after low=1, level 2 outranks level 0
        irq_in = 8'h05;
        wait_int("R8 order after specific rotate");
        do_ack(2);
        send_cmd(3'd1, 2);
        wait_int("R8 level 0 after 2");
        do_ack(0);
        send_cmd(3'd1, 0);
        irq_in = 8'h00;
        idle(4);

        chk(exp_q.size() == 0, "R5 all grants seen", exp_q.size(), 0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule